// File: doc/BRIEF.md
# MAC Transmit/Receive Command Controller

This block is the command register of a network controller's transmit and receive paths, paired with a small control engine. A host writes one 32-bit word to start or gracefully stop either direction, abort a direction immediately, launch a global soft reset, or raise a software interrupt. Reads return the live state: whether each direction is running and whether a soft reset is still in progress. Bits that only issue commands read as zero.

Each direction is modelled as an idle/active state. A packet-in-progress input lets a graceful stop wait for the end of the current frame. An abort flushes that direction's FIFOs through a request/acknowledge handshake. When the acknowledge arrives, the block sends a one-cycle reset-complete event to the interrupt logic. A soft reset aborts both directions and sends a one-cycle clear pulse to the other soft-resettable registers. It reads as busy until both flushes have been acknowledged.

Top module: `mac_cmd_ctrl`

## Requirements
- R1: After hard reset `host_rdata` is 0. At all times, only bit 8 (soft reset busy), bit 2 (receive running) and bit 0 (transmit running) of `host_rdata` may be 1.
- R2: A write with bit 0 (transmit) or bit 2 (receive) set starts that direction if it is idle with no flush outstanding. The direction then reads 1 from the cycle after the write for as long as it runs.
- R3: A write with bit 1 (transmit) or bit 3 (receive) set stops a running direction. With no packet in progress it goes idle after the write edge. Otherwise it stays running until the packet-in-progress input is seen low, then goes idle at that edge.
- R4: When the stop bit and the start bit of one direction are written together, the start is ignored.
- R5: A write with bit 4 (transmit) or bit 5 (receive) set forces that direction idle at the write edge, even mid-packet, and raises its flush request.
- R6: A flush request stays high until its acknowledge is sampled high. It drops at that edge, and the direction's reset-complete output pulses high for exactly that one following cycle.
- R7: A write with bit 8 set, when no soft reset is running, aborts both directions. Bit 8 reads 1 from the next cycle until both flushes are acknowledged. The soft-clear output pulses for one cycle.
- R8: A write with bit 8 set while a soft reset is running neither restarts it nor produces a second soft-clear pulse.
- R9: A write with bit 7 set produces a one-cycle software interrupt pulse in the next cycle. Bit 7 reads 0.
- R10: A start written while that direction's flush request is outstanding is ignored.
- R11: An abort beats a start or stop written in the same word for the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Live register read value |
| tx_pkt_busy | input | 1 | Transmit packet in progress |
| tx_flush_ack | input | 1 | Transmit FIFO flush acknowledge |
| tx_active | output | 1 | Transmit engine running |
| tx_flush_req | output | 1 | Transmit FIFO flush request |
| tx_rst_done | output | 1 | Transmit reset complete event |
| rx_pkt_busy | input | 1 | Receive packet in progress |
| rx_flush_ack | input | 1 | Receive FIFO flush acknowledge |
| rx_active | output | 1 | Receive engine running |
| rx_flush_req | output | 1 | Receive FIFO flush request |
| rx_rst_done | output | 1 | Receive reset complete event |
| soft_clr | output | 1 | One-cycle soft reset pulse to other registers |
| swi_evt | output | 1 | One-cycle software interrupt event |

## Verification
Two functions can fall in the same cycle: a command from the host in one written word and a state change the engine is already making. The bench provokes this by sweeping all 64 combinations of the six direction command bits, starting from each mix of idle and running directions. It also writes start during an outstanding flush and writes a second soft reset before the first has been acknowledged. It judges each case against expected state computed arithmetically from the priority abort > stop > start.

// File: rtl/mac_cmd_pkg.sv
package mac_cmd_pkg;
  localparam int NDIR    = 2;
  localparam int RST_POS = 8;
  localparam int SWI_POS = 7;

  // direction 0 = transmit, 1 = receive
  function automatic int en_pos(input int d);
    return 2 * d;
  endfunction

  function automatic int dis_pos(input int d);
    return 2 * d + 1;
  endfunction

  function automatic int abort_pos(input int d);
    return 4 + d;
  endfunction
endpackage

// File: rtl/cmd_dir_engine.sv
module cmd_dir_engine (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  input  logic abort_req,
  input  logic pkt_busy,
  input  logic flush_ack,
  output logic active,
  output logic flush_req,
  output logic flush_fin,
  output logic done
);
  logic stopping;
  logic start_ok;

  assign flush_fin = flush_req & flush_ack;
  assign start_ok  = en_req & ~dis_req & ~abort_req & ~active & ~flush_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      stopping  <= 1'b0;
      flush_req <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= flush_fin;
      if (abort_req) begin
        active    <= 1'b0;
        stopping  <= 1'b0;
        flush_req <= 1'b1;
      end else begin
        if (flush_fin) flush_req <= 1'b0;
        if (dis_req && active) begin
          if (!pkt_busy) begin
            active   <= 1'b0;
            stopping <= 1'b0;
          end else begin
            stopping <= 1'b1;
          end
        end else if (stopping && !pkt_busy) begin
          active   <= 1'b0;
          stopping <= 1'b0;
        end else if (start_ok) begin
          active <= 1'b1;
        end
      end
    end
  end

  p_abort_forces_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!active && flush_req));
  p_fin_gives_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_fin && !abort_req) |=> (done && !flush_req));
  p_done_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(flush_fin));
  p_hold_during_packet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pkt_busy && !abort_req) |=> active);
  p_idle_while_flushing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !active);
  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !dis_req && !abort_req && !active && !flush_req) |=> active);
  p_disable_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req && !active) |=> !active);
endmodule

// File: rtl/mac_cmd_ctrl.sv
module mac_cmd_ctrl #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             tx_pkt_busy,
  input  logic             tx_flush_ack,
  output logic             tx_active,
  output logic             tx_flush_req,
  output logic             tx_rst_done,
  input  logic             rx_pkt_busy,
  input  logic             rx_flush_ack,
  output logic             rx_active,
  output logic             rx_flush_req,
  output logic             rx_rst_done,
  output logic             soft_clr,
  output logic             swi_evt
);
  import mac_cmd_pkg::*;

  localparam int HI_W = REG_W - RST_POS - 1;

  logic [NDIR-1:0] en_req, dis_req, ab_req, pkt_busy, f_ack;
  logic [NDIR-1:0] act, freq, ffin, dn, pend;
  logic            srst_busy, srst_start;
  logic            unused_wbits;

  assign unused_wbits = ^{host_wdata[REG_W-1:RST_POS+1], host_wdata[6]};

  assign srst_busy  = |pend;
  assign srst_start = host_wr & host_wdata[RST_POS] & ~srst_busy;

  assign pkt_busy = {rx_pkt_busy, tx_pkt_busy};
  assign f_ack    = {rx_flush_ack, tx_flush_ack};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign en_req[d]  = host_wr & host_wdata[en_pos(d)];
    assign dis_req[d] = host_wr & host_wdata[dis_pos(d)];
    assign ab_req[d]  = (host_wr & host_wdata[abort_pos(d)]) | srst_start;

    cmd_dir_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_req    (en_req[d]),
      .dis_req   (dis_req[d]),
      .abort_req (ab_req[d]),
      .pkt_busy  (pkt_busy[d]),
      .flush_ack (f_ack[d]),
      .active    (act[d]),
      .flush_req (freq[d]),
      .flush_fin (ffin[d]),
      .done      (dn[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      soft_clr <= 1'b0;
      swi_evt  <= 1'b0;
    end else begin
      soft_clr <= srst_start;
      swi_evt  <= host_wr & host_wdata[SWI_POS];
      for (int d = 0; d < NDIR; d++) begin
        if (srst_start)   pend[d] <= 1'b1;
        else if (ffin[d]) pend[d] <= 1'b0;
      end
    end
  end

  function automatic logic [REG_W-1:0] pack_status(input logic busy,
                                                   input logic [NDIR-1:0] run);
    logic [REG_W-1:0] r;
    r = '0;
    r[RST_POS] = busy;
    for (int d = 0; d < NDIR; d++) r[en_pos(d)] = run[d];
    return r;
  endfunction

  assign host_rdata   = pack_status(srst_busy, act);
  assign tx_active    = act[0];
  assign rx_active    = act[1];
  assign tx_flush_req = freq[0];
  assign rx_flush_req = freq[1];
  assign tx_rst_done  = dn[0];
  assign rx_rst_done  = dn[1];

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[REG_W-1:RST_POS+1] == HI_W'(0)) && (host_rdata[7:3] == 5'd0)
    && !host_rdata[1]);
  p_rst_reads_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_start |=> (host_rdata[RST_POS] && tx_flush_req && rx_flush_req && soft_clr));
  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !soft_clr);
  p_rst_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && host_wr && host_wdata[RST_POS]) |=> !soft_clr);
  p_swi_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata[SWI_POS]) |=> swi_evt);
  p_swi_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swi_evt |-> $past(host_wr));
endmodule

// File: tb/sim_mac_cmd_ctrl.sv
module sim_mac_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_pkt_busy = 1'b0, tx_flush_ack = 1'b0;
  logic        rx_pkt_busy = 1'b0, rx_flush_ack = 1'b0;
  logic        tx_active, tx_flush_req, tx_rst_done;
  logic        rx_active, rx_flush_req, rx_rst_done;
  logic        soft_clr, swi_evt;
  int          n_chk = 0;
  int          n_err = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  mac_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .tx_pkt_busy(tx_pkt_busy), .tx_flush_ack(tx_flush_ack), .tx_active(tx_active),
    .tx_flush_req(tx_flush_req), .tx_rst_done(tx_rst_done),
    .rx_pkt_busy(rx_pkt_busy), .rx_flush_ack(rx_flush_ack), .rx_active(rx_active),
    .rx_flush_req(rx_flush_req), .rx_rst_done(rx_rst_done),
    .soft_clr(soft_clr), .swi_evt(swi_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_cmd(input logic [31:0] data);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = data;
    @(negedge clk);
    host_wr = 1'b0;
    host_wdata = '0;
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  // {tx_flush, rx_flush, rd[8], rd[2], rd[0]}
  function automatic logic [31:0] snap();
    return {27'd0, tx_flush_req, rx_flush_req, host_rdata[8], host_rdata[2], host_rdata[0]};
  endfunction

  initial begin
    hard_reset();
    chk("R1 reset read value", host_rdata, 32'h0);
    chk("R1 reset outputs", {26'd0, tx_active, rx_active, tx_flush_req, rx_flush_req,
        soft_clr, swi_evt}, 32'h0);

    // sweep: start state per direction x all direction command combinations
    for (int st = 0; st < 4; st++) begin
      for (int cmd = 0; cmd < 64; cmd++) begin
        logic [1:0] ef, ea;
        logic       other;
        hard_reset();
        if (st != 0) wr_cmd((st[0] ? 32'h1 : 32'h0) | (st[1] ? 32'h4 : 32'h0));
        wr_cmd(32'(cmd));
        for (int d = 0; d < 2; d++) begin
          logic ab, ds, en;
          ab = cmd[4 + d];
          ds = cmd[2 * d + 1];
          en = cmd[2 * d];
          ef[d] = ab;
          ea[d] = !ab && !ds && (st[d] || en);
        end
        other = |(host_rdata & ~32'h0000_0005);
        chk($sformatf("R1 R2 R4 R5 R11 st=%0d cmd=%0d", st, cmd),
            {other, tx_flush_req, rx_flush_req, host_rdata[2], host_rdata[0]},
            {1'b0, ef[0], ef[1], ea[1], ea[0]});
      end
    end

    // R3: graceful stop waits for packet end (transmit)
    hard_reset();
    wr_cmd(32'h5);
    tx_pkt_busy = 1'b1;
    wr_cmd(32'h2);
    tick(); tick();
    chk("R3 tx held while packet runs", {31'd0, host_rdata[0]}, 32'h1);
    tx_pkt_busy = 1'b0;
    tick();
    chk("R3 tx idle after packet end", {31'd0, host_rdata[0]}, 32'h0);
    chk("R3 rx untouched", {31'd0, host_rdata[2]}, 32'h1);
    // R3: receive side
    rx_pkt_busy = 1'b1;
    wr_cmd(32'h8);
    chk("R3 rx held while packet runs", {31'd0, host_rdata[2]}, 32'h1);
    rx_pkt_busy = 1'b0;
    tick();
    chk("R3 rx idle after packet end", {31'd0, host_rdata[2]}, 32'h0);

    // R5/R6/R10: abort mid-packet, flush handshake, start ignored while flushing
    hard_reset();
    wr_cmd(32'h1);
    tx_pkt_busy = 1'b1;
    wr_cmd(32'h10);
    chk("R5 abort mid-packet", snap(), 32'h10);
    tx_pkt_busy = 1'b0;
    wr_cmd(32'h1);
    chk("R10 start ignored during flush", snap(), 32'h10);
    tick(); tick();
    chk("R6 flush held without ack", {30'd0, tx_flush_req, tx_rst_done}, 32'h2);
    tx_flush_ack = 1'b1;
    tick();
    tx_flush_ack = 1'b0;
    chk("R6 flush done pulse", {30'd0, tx_flush_req, tx_rst_done}, 32'h1);
    tick();
    chk("R6 done single cycle", {31'd0, tx_rst_done}, 32'h0);
    wr_cmd(32'h1);
    chk("R2 start after flush", {31'd0, host_rdata[0]}, 32'h1);

    // R7/R8: soft reset with both running
    hard_reset();
    wr_cmd(32'h5);
    wr_cmd(32'h100);
    chk("R7 soft reset entry", snap(), 32'h1C);
    chk("R7 soft clear pulse", {31'd0, soft_clr}, 32'h1);
    tick();
    chk("R7 soft clear single", {31'd0, soft_clr}, 32'h0);
    tx_flush_ack = 1'b1;
    tick();
    tx_flush_ack = 1'b0;
    chk("R7 busy until both acked", snap(), 32'h0C);
    chk("R6 tx done in soft reset", {30'd0, tx_rst_done, rx_rst_done}, 32'h2);
    wr_cmd(32'h100);
    chk("R8 second reset ignored", {27'd0, soft_clr, snap()[3:0]}, 32'h0C);
    rx_flush_ack = 1'b1;
    tick();
    rx_flush_ack = 1'b0;
    chk("R7 busy clears", snap(), 32'h00);
    chk("R6 rx done in soft reset", {30'd0, tx_rst_done, rx_rst_done}, 32'h1);

    // R9: software interrupt
    wr_cmd(32'h80);
    chk("R9 swi pulse", {31'd0, swi_evt}, 32'h1);
    chk("R9 swi reads zero", host_rdata, 32'h0);
    tick();
    chk("R9 swi single cycle", {31'd0, swi_evt}, 32'h0);

    // R1: upper bits written do not read back
    wr_cmd(32'hFFFF_FE40);
    chk("R1 unused bits read zero", host_rdata & 32'hFFFF_FEFA, 32'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule